// File: doc/BRIEF.md
# Programmable Degamma Lookup Unit

This block is the linearising stage that sits ahead of a pixel pipe's colour-space matrix. A host loads a single 35-entry table of 17-bit values through three write-only registers: a control word, a table pointer and a table data port. Red, green and blue all pass through the same table. Each input channel is an unsigned 16-bit number with 13 fractional bits, so 1.0 is 0x2000 and the largest code is just under 8.0. Inputs from 0 to 1.0 use 32 equal segments bounded by entries 0..32. Two wider segments reach 3.0 (entry 33) and 7.0 (entry 34). Anything above 7.0 clamps to entry 34. Outputs carry 16 fractional bits, so 1.0 is 0x10000.

A typical load writes the pointer with the increment flag clear to choose a start entry. It then writes the pointer again with the flag set, and streams values through the data port. The pointer stops one place past the last entry and never wraps. The control word also holds a post-matrix gamma enable and a two-bit gamma precision code. This block does not act on those two fields. It only drives them to outputs for the next stage.

Top module: `degamma_lut_unit`

## Requirements
- R1: After reset all of the following hold. Entry i holds i*0x800 for i up to 32, and entries 33 and 34 hold 0x10000. The degamma enable, post-gamma enable, gamma mode, pointer and increment flag are all zero. `pixOutValid` and `pixOut` are zero.
- R2: A write to address 0 loads the control word. Bit 31 enables degamma. Bit 30 drives `postGammaEn`. Bits [1:0] drive `gammaMode` (0 = 8-bit, 1 = 10-bit, 2 = 12-bit, 3 = split). Both outputs update on the clock edge of the write.
- R3: A write to address 1 copies bit 15 into the increment flag. If bit 15 is clear, bits [5:0] load the pointer. If bit 15 is set, the pointer keeps its value whatever bits [5:0] hold.
- R4: A write to address 2 stores bits [16:0] into the entry named by the pointer. The pointer then advances by one only if the increment flag is set. With the flag clear, repeated writes go to the same entry.
- R5: The pointer saturates at 35. A data write while the pointer is 35 or more changes no entry. No write ever wraps to entry 0.
- R6: For inputs x below 0x2000, let i = x[12:8] and f = x[7:0]. The output is floor((T[i]*(256-f) + T[i+1]*f)/256).
- R7: For 0x2000 <= x < 0x6000, let f = x-0x2000. The output is floor((T[32]*(16384-f) + T[33]*f)/16384).
- R8: For 0x6000 <= x < 0xE000, let f = x-0x6000. The output is floor((T[33]*(32768-f) + T[34]*f)/32768).
- R9: For x >= 0xE000, the output equals T[34].
- R10: `pixOutValid` follows `pixInValid` exactly two cycles later, in both modes. The unit accepts a new pixel on every cycle.
- R11: A pixel accepted while degamma is disabled leaves as its input, zero-extended to 17 bits per channel.
- R12: One table serves all three channels, with channel 0 in the low bits of `pixIn`/`pixOut`. A table write completed before a pixel is presented applies to that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 pointer, 2 data |
| regWrData | input | 32 | Host write data |
| pixInValid | input | 1 | Input pixel valid |
| pixIn | input | 48 | Three 16-bit channels, 13 fractional bits |
| pixOutValid | output | 1 | Output pixel valid |
| pixOut | output | 51 | Three 17-bit channels, 16 fractional bits |
| postGammaEn | output | 1 | Post-matrix gamma enable from the control word |
| gammaMode | output | 2 | Gamma precision code from the control word |

## Verification
A back-to-back stream sweeps channel 0 upward and channel 1 downward across the whole 16-bit input range, with channel 2 stepping at a coprime stride. Each sweep runs once with the reset ramp and once with an irregular, non-monotonic table. The ramp makes the fine region an exact multiply by eight. The irregular table exposes any wrong entry pair or wrong fraction width. Single pixels placed at every segment edge (0x00FF/0x0100, 0x1FFF/0x2000, 0x5FFF/0x6000, 0xDFFF/0xE000, 0xFFFF) separate the four regions. The pointer tests write with the flag set and stray index bits, run past the last entry, and repeat writes with the flag clear. Each of these outcomes is read back through pixels that land exactly on table entries.

// File: rtl/degamma_pkg.sv
package degamma_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 17;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_INDEX = 2'd1,
    ADDR_DATA  = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic              wrEn;
    logic              autoInc;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
    logic              preEn;
  } lutStrobe_t;
endpackage

// File: rtl/degamma_ctrl.sv
module degamma_ctrl
  import degamma_pkg::*;
#(
  parameter int ENTRIES = 35,
  parameter int INC_BIT = 15,
  parameter int PRE_BIT = 31,
  parameter int POST_BIT = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output lutStrobe_t  strobe,
  output logic        postGammaEn,
  output logic [1:0]  gammaMode
);
  localparam logic [IDX_W-1:0] LAST_PTR = IDX_W'(ENTRIES);

  logic             preEn;
  logic             autoInc;
  logic [IDX_W-1:0] ptr;
  logic             dataWr;

  assign dataWr = regWrEn && (regAddr == ADDR_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preEn       <= 1'b0;
      postGammaEn <= 1'b0;
      gammaMode   <= 2'd0;
      autoInc     <= 1'b0;
      ptr         <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL: begin
          preEn       <= regWrData[PRE_BIT];
          postGammaEn <= regWrData[POST_BIT];
          gammaMode   <= regWrData[1:0];
        end
        ADDR_INDEX: begin
          autoInc <= regWrData[INC_BIT];
          if (!regWrData[INC_BIT]) ptr <= regWrData[IDX_W-1:0];
        end
        ADDR_DATA: begin
          if (autoInc && (ptr < LAST_PTR)) ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn    = dataWr && (ptr < LAST_PTR);
    strobe.autoInc = autoInc;
    strobe.wrIdx   = ptr;
    strobe.wrData  = regWrData[DATA_W-1:0];
    strobe.preEn   = preEn;
  end
endmodule

// File: rtl/degamma_datapath.sv
module degamma_datapath
  import degamma_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 13,
  parameter int SEG_BITS = 5,
  parameter int CHANNELS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lutStrobe_t                 strobe,
  input  logic                       pixInValid,
  input  logic [CHANNELS*IN_W-1:0]   pixIn,
  output logic                       pixOutValid,
  output logic [CHANNELS*DATA_W-1:0] pixOut
);
  localparam int SEGS    = 1 << SEG_BITS;
  localparam int ENTRIES = SEGS + 3;
  localparam int FINE_W  = FRAC_W - SEG_BITS;
  localparam int WT_SH   = FRAC_W + 2;
  localparam int WT_W    = WT_SH + 1;
  localparam int PROD_W  = DATA_W + WT_W + 1;
  localparam int OUT_ONE = 1 << (DATA_W - 1);
  localparam int STEP    = OUT_ONE >> SEG_BITS;
  localparam int ONE_IN   = 1 << FRAC_W;
  localparam int THREE_IN = 3 * ONE_IN;
  localparam int SEVEN_IN = 7 * ONE_IN;
  localparam logic [WT_W-1:0] WT_FULL = WT_W'(1 << WT_SH);

  function automatic logic [DATA_W-1:0] resetVal(int e);
    return (e <= SEGS) ? DATA_W'(e * STEP) : DATA_W'(OUT_ONE);
  endfunction

  logic [DATA_W-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= resetVal(e);
    end else if (strobe.wrEn) begin
      tbl[strobe.wrIdx] <= strobe.wrData;
    end
  end

  logic s1Valid;
  logic s1Pre;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      s1Pre       <= 1'b0;
      pixOutValid <= 1'b0;
    end else begin
      s1Valid     <= pixInValid;
      s1Pre       <= strobe.preEn;
      pixOutValid <= s1Valid;
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [IN_W-1:0]   x;
    logic [IDX_W-1:0]  lo;
    logic [WT_W-1:0]   wt;
    logic [IN_W-1:0]   s1In;
    logic [IDX_W-1:0]  s1Lo;
    logic [WT_W-1:0]   s1Wt;
    logic [IDX_W-1:0]  hiIdx;
    logic [PROD_W-1:0] prod;
    logic [DATA_W-1:0] interp;

    assign x = pixIn[ch*IN_W +: IN_W];

    always_comb begin
      if (32'(x) < ONE_IN) begin
        lo = IDX_W'(x[FRAC_W-1 -: SEG_BITS]);
        wt = WT_W'(x[FINE_W-1:0]) << (WT_SH - FINE_W);
      end else if (32'(x) < THREE_IN) begin
        lo = IDX_W'(SEGS);
        wt = WT_W'(32'(x) - ONE_IN) << 1;
      end else if (32'(x) < SEVEN_IN) begin
        lo = IDX_W'(SEGS + 1);
        wt = WT_W'(32'(x) - THREE_IN);
      end else begin
        lo = IDX_W'(SEGS + 1);
        wt = WT_FULL;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        s1In <= '0;
        s1Lo <= '0;
        s1Wt <= '0;
      end else if (pixInValid) begin
        s1In <= x;
        s1Lo <= lo;
        s1Wt <= wt;
      end
    end

    assign hiIdx  = IDX_W'(s1Lo + 1'b1);
    assign prod   = PROD_W'(tbl[s1Lo]) * PROD_W'(WT_FULL - s1Wt)
                  + PROD_W'(tbl[hiIdx]) * PROD_W'(s1Wt);
    assign interp = DATA_W'(prod >> WT_SH);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pixOut[ch*DATA_W +: DATA_W] <= '0;
      end else if (s1Valid) begin
        pixOut[ch*DATA_W +: DATA_W] <= s1Pre ? interp : DATA_W'(s1In);
      end
    end
  end
endmodule

// File: rtl/degamma_lut_unit.sv
module degamma_lut_unit
  import degamma_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 13,
  parameter int SEG_BITS = 5,
  parameter int CHANNELS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [1:0]                 regAddr,
  input  logic [31:0]                regWrData,
  input  logic                       pixInValid,
  input  logic [CHANNELS*IN_W-1:0]   pixIn,
  output logic                       pixOutValid,
  output logic [CHANNELS*DATA_W-1:0] pixOut,
  output logic                       postGammaEn,
  output logic [1:0]                 gammaMode
);
  localparam int ENTRIES = (1 << SEG_BITS) + 3;

  lutStrobe_t ctrlStrobe;

  degamma_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(ctrlStrobe),
    .postGammaEn(postGammaEn), .gammaMode(gammaMode)
  );

  degamma_datapath #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .SEG_BITS(SEG_BITS), .CHANNELS(CHANNELS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe),
    .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: rtl/degamma_lut_chk.sv
module degamma_lut_chk
  import degamma_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        pixInValid,
  input logic [47:0] pixIn,
  input logic        pixOutValid,
  input logic [50:0] pixOut,
  input logic        postGammaEn,
  input logic [1:0]  gammaMode,
  input lutStrobe_t  strobe
);
  function automatic logic [50:0] widen(logic [47:0] v);
    return {1'b0, v[47:32], 1'b0, v[31:16], 1'b0, v[15:0]};
  endfunction

  // R10: output valid trails input valid by two cycles
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid == $past(pixInValid, 2));

  // R11: disabled stage returns the input unchanged
  a_r11_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (pixInValid && !strobe.preEn) |=> ##1 (pixOut == widen($past(pixIn, 2))));

  // R5: pointer never passes one beyond the last entry
  a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrIdx <= 6'd35) || $stable(strobe.wrIdx) || (regWrEn && regAddr == ADDR_INDEX));

  // R4: an accepted data write with the flag set advances the pointer
  a_r4_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.autoInc) |=> (strobe.wrIdx == $past(strobe.wrIdx) + 6'd1));

  // R2: control fields reach the outputs on the write edge
  a_r2_ctrl_out: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTRL) |=>
      (postGammaEn == $past(regWrData[30]) && gammaMode == $past(regWrData[1:0])));
endmodule

bind degamma_lut_unit degamma_lut_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .pixInValid(pixInValid), .pixIn(pixIn),
  .pixOutValid(pixOutValid), .pixOut(pixOut), .postGammaEn(postGammaEn),
  .gammaMode(gammaMode), .strobe(ctrlStrobe)
);

// File: tb/degamma_lut_unit_tb.sv
module degamma_lut_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic        pixInValid = 1'b0;
  logic [47:0] pixIn = 48'd0;
  logic        pixOutValid;
  logic [50:0] pixOut;
  logic        postGammaEn;
  logic [1:0]  gammaMode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  longint mdl [35];
  int  mPtr = 0;
  bit  mInc = 1'b0;
  bit  mPre = 1'b0;

  always #10 clk = ~clk;

  degamma_lut_unit u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut),
    .postGammaEn(postGammaEn), .gammaMode(gammaMode)
  );

  function automatic longint expOne(longint x);
    longint f;
    if (!mPre) return x;
    if (x < 'h2000) begin
      f = x % 256;
      return (mdl[x / 256] * (256 - f) + mdl[x / 256 + 1] * f) / 256;
    end else if (x < 'h6000) begin
      f = x - 'h2000;
      return (mdl[32] * (16384 - f) + mdl[33] * f) / 16384;
    end else if (x < 'hE000) begin
      f = x - 'h6000;
      return (mdl[33] * (32768 - f) + mdl[34] * f) / 32768;
    end
    return mdl[34];
  endfunction

  function automatic logic [50:0] expPix(logic [47:0] p);
    logic [50:0] r;
    for (int c = 0; c < 3; c++) r[c*17 +: 17] = 17'(expOne(longint'(p[c*16 +: 16])));
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) mPre = d[31];
    else if (a == 2'd1) begin
      mInc = d[15];
      if (!d[15]) mPtr = int'(d[5:0]);
    end else if (a == 2'd2) begin
      if (mPtr < 35) begin
        mdl[mPtr] = longint'(d[16:0]);
        if (mInc) mPtr++;
      end
    end
  endtask

  task automatic onePix(string req, logic [15:0] r, logic [15:0] g, logic [15:0] b);
    logic [47:0] p;
    p = {b, g, r};
    @(negedge clk);
    pixInValid = 1'b1; pixIn = p;
    @(negedge clk);
    pixInValid = 1'b0; pixIn = '0;
    check("R10", 64'(pixOutValid), 64'd0);
    @(negedge clk);
    check("R10", 64'(pixOutValid), 64'd1);
    check(req, 64'(pixOut), 64'(expPix(p)));
  endtask

  task automatic stream(string req, int n);
    logic [50:0] ring [4];
    for (int k = 0; k < n + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R10", 64'(pixOutValid), 64'd1);
        check(req, 64'(pixOut), 64'(ring[k % 4]));
      end
      if (k < n) begin
        logic [47:0] p;
        p = {16'(k * 211 + 7), 16'(16'hFFFF - 16'(k * 37)), 16'(k * 37)};
        pixInValid = 1'b1; pixIn = p;
        ring[(k + 2) % 4] = expPix(p);
      end else begin
        pixInValid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 35; e++) mdl[e] = (e <= 32) ? longint'(e * 2048) : 'h10000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1", 64'(pixOutValid), 64'd0);
    check("R1", 64'(pixOut), 64'd0);
    check("R1", 64'({postGammaEn, gammaMode}), 64'd0);

    // R11: disabled after reset, so input passes through
    onePix("R11", 16'h1234, 16'hFFFF, 16'h0000);
    stream("R11", 300);

    // R2: control fields
    regWrite(2'd0, 32'h4000_0002);
    check("R2", 64'({postGammaEn, gammaMode}), 64'h6);
    onePix("R11", 16'h2345, 16'hE001, 16'h0100);
    regWrite(2'd0, 32'h8000_0003);
    check("R2", 64'({postGammaEn, gammaMode}), 64'h3);

    // R1/R6: reset ramp gives x*8 in the fine region
    onePix("R1", 16'h0000, 16'h1000, 16'h2000);
    check("R6", 64'(pixOut[16:0]), 64'd0);
    onePix("R6", 16'h00FF, 16'h0100, 16'h1FFF);
    check("R6", 64'(pixOut[16:0]), 64'h7F8);
    stream("R6", 1772);

    // R3/R4: load an irregular table from entry 0
    regWrite(2'd1, 32'h0000_0000);
    regWrite(2'd1, 32'h0000_8000);
    for (int e = 0; e < 35; e++) regWrite(2'd2, 32'((e * 12345 + 999) % 131072));
    onePix("R6", 16'h00FF, 16'h0100, 16'h1FFF);
    onePix("R7", 16'h2000, 16'h5FFF, 16'h3ABC);
    onePix("R8", 16'h6000, 16'hDFFF, 16'h9876);
    onePix("R9", 16'hE000, 16'hFFFF, 16'hF123);
    check("R9", 64'(pixOut[16:0]), 64'(mdl[34]));
    stream("R12", 1772);

    // R3: flag write with stray index bits keeps the pointer
    regWrite(2'd1, 32'h0000_0005);
    regWrite(2'd1, 32'h0000_8014);
    regWrite(2'd2, 32'h0001_5555);
    onePix("R3", 16'h0500, 16'h1400, 16'h0600);
    check("R3", 64'(pixOut[16:0]), 64'h15555);

    // R4: flag clear keeps writing the same entry
    regWrite(2'd1, 32'h0000_0007);
    regWrite(2'd2, 32'h0000_1111);
    regWrite(2'd2, 32'h0000_2222);
    onePix("R4", 16'h0700, 16'h0800, 16'h0600);
    check("R4", 64'(pixOut[16:0]), 64'h2222);

    // R5: saturation at the last entry, no wrap
    regWrite(2'd1, 32'h0000_001E);
    regWrite(2'd1, 32'h0000_8000);
    for (int e = 0; e < 10; e++) regWrite(2'd2, 32'h0000_0100 * (e + 1));
    onePix("R5", 16'h1E00, 16'hFFFF, 16'h0000);
    check("R5", 64'(pixOut[33:17]), 64'h500);
    onePix("R5", 16'h2000, 16'h6000, 16'h0001);
    onePix("R12", 16'h7777, 16'h0123, 16'hC000);

    // R11 again: disable mid-run
    regWrite(2'd0, 32'h0000_0000);
    onePix("R11", 16'hFFFF, 16'h8000, 16'h0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule